// File: doc/BRIEF.md
# Receive Error Statistics Counter Bank

This block keeps two receive error statistics for a network receive path. The first counts frames whose frame check sequence was bad. The second counts frames in which the line decoder saw at least one illegal symbol. The receive path reports each finished frame as a single-cycle event. The event carries the frame length in bytes, a bad-CRC flag, an illegal-symbol flag and the level of the receive-enable control.

Software reads the counters through a small read port. A read returns the current count and empties the counter in the same cycle. Each counter stops at its all-ones value instead of wrapping. A long polling interval can therefore under-report a burst of errors, but it never produces a small, wrapped-around number.

There is no destination address input. Every frame the receive path reports is counted, whatever it was addressed to.

Top module: `rxerr_stat_bank`

## Requirements
- R1: Each counter is CNT_W bits wide (32 by default) and holds zero after reset. The read data output also resets to zero.
- R2: A read takes effect when `rd_en` is high at a clock edge. `rd_data` shows the counter value from before that edge, starting in the cycle after it, and holds until the next read. The counter that was read becomes zero.
- R3: A counter at all ones (0xFFFF_FFFF at the default width) stays at all ones when further qualifying events arrive. It does not wrap.
- R4: The CRC error counter counts an event only if `ev_crc_bad` is 1 and `ev_len` is at least 64. `ev_len` is the frame length in bytes, from the destination address through the CRC field.
- R5: While `rx_en` is 0 in the cycle of an event, neither counter changes because of that event.
- R6: The illegal-symbol counter adds exactly one for every event with `ev_sym_bad` = 1, at any frame length.
- R7: An event with both flags set adds one to each counter. One event never adds more than one to either counter.
- R8: The CRC error counter is read at byte offset 0x000 and the illegal-symbol counter at 0x004. Each needs an exact match on the whole `rd_addr`.
- R9: If a read and a qualifying event hit the same counter in the same cycle, the read returns the value from before that edge and the counter is left at 1.
- R10: A read at any other offset returns zero on `rd_data` and changes neither counter.
- R11: An event is already included in the value returned by a read issued in the cycle after the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Frame-end event strobe, one cycle per frame |
| ev_len | input | LEN_W (16) | Frame length in bytes, destination address through CRC |
| ev_crc_bad | input | 1 | Frame failed its CRC check |
| ev_sym_bad | input | 1 | Frame contained at least one illegal line symbol |
| rx_en | input | 1 | Receive enable level; events are ignored while low |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W (12) | Byte offset of the counter to read |
| rd_data | output | CNT_W (32) | Value returned by the most recent read |

## Verification
The risky coincidence is a clear-on-read and a counting event landing on the same counter at one clock edge. An increment can be lost, or the cleared value can come back as the read result. The bench drives frame events in the same cycle as reads of the same counter, of the other counter and of unmapped offsets. It judges each read result against a model in the bench that returns the value before the edge and then applies the increment on top of the clear. A narrow counter width is used so that the same collision can also be provoked while the counter is saturated.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;

   // Counter slots; the order is used as the index into the counter array
   typedef enum int unsigned {
      CTR_CRC = 0,
      CTR_SYM = 1
   } ctr_idx_e;

   localparam int unsigned NUM_CTR = 2;

   // All-ones limit for a counter of a given width
   function automatic logic [63:0] sat_limit(input int unsigned w);
      logic [63:0] v;
      v = '0;
      for (int unsigned b = 0; b < w && b < 64; b++) v[b] = 1'b1;
      return v;
   endfunction

endpackage

// File: rtl/rxstat_qualify.sv
module rxstat_qualify
   import rxstat_pkg::*;
#(
   parameter int unsigned LEN_W   = 16,
   parameter int unsigned MIN_LEN = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_valid,
   input  logic [LEN_W-1:0] ev_len,
   input  logic             ev_crc_bad,
   input  logic             ev_sym_bad,
   input  logic             rx_en,
   output logic [NUM_CTR-1:0] inc
);

   localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);

   logic live;
   logic long_enough;

   always_comb begin
      live        = ev_valid & rx_en;
      long_enough = (ev_len >= MIN_L);
      inc         = '0;
      inc[CTR_CRC] = live & ev_crc_bad & long_enough;
      inc[CTR_SYM] = live & ev_sym_bad;
   end

   // R5: no increment request while reception is disabled
   assert_gate_rxen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |-> (inc == '0));

   // R4: runt frames never request a CRC error count
   assert_runt_crc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_len < MIN_L) |-> !inc[CTR_CRC]);

endmodule

// File: rtl/rxstat_sat_ctr.sv
module rxstat_sat_ctr #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_nxt;
   logic             at_max;

   always_comb begin
      at_max = (cnt == CNT_MAX);
      if (clr)
         cnt_nxt = inc ? CNT_ONE : '0;
      else if (inc && !at_max)
         cnt_nxt = cnt + CNT_ONE;
      else
         cnt_nxt = cnt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_nxt;
   end

   assert_sat_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX));

   assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !inc) |=> (cnt == '0));

   assert_read_collide_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && inc) |=> (cnt == CNT_ONE));

   assert_single_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_ONE));

endmodule

// File: rtl/rxstat_rd_decode.sv
module rxstat_rd_decode
   import rxstat_pkg::*;
#(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned CRC_OFS = 'h000,
   parameter int unsigned SYM_OFS = 'h004
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [NUM_CTR-1:0] hit
);

   for (genvar i = 0; i < NUM_CTR; i++) begin : g_slot
      localparam logic [ADDR_W-1:0] OFS =
         (i == CTR_CRC) ? ADDR_W'(CRC_OFS) : ADDR_W'(SYM_OFS);
      assign hit[i] = rd_en && (rd_addr == OFS);
   end

   // R8: a read selects at most one counter
   assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));

   assert_no_hit_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (hit == '0));

endmodule

// File: rtl/rxerr_stat_bank.sv
module rxerr_stat_bank
   import rxstat_pkg::*;
#(
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned LEN_W   = 16,
   parameter int unsigned MIN_LEN = 64,
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned CRC_OFS = 'h000,
   parameter int unsigned SYM_OFS = 'h004
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_valid,
   input  logic [LEN_W-1:0]  ev_len,
   input  logic              ev_crc_bad,
   input  logic              ev_sym_bad,
   input  logic              rx_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_data
);

   // Elaboration-time parameter checks
   if (CNT_W < 2 || CNT_W > 64) begin : g_bad_cnt_w
      $error("rxerr_stat_bank: CNT_W must lie in 2..64");
   end
   if (CRC_OFS == SYM_OFS) begin : g_bad_ofs
      $error("rxerr_stat_bank: counter offsets must differ");
   end
   if (ADDR_W < 3 || ADDR_W > 32) begin : g_bad_addr_w
      $error("rxerr_stat_bank: ADDR_W must lie in 3..32");
   end
   if (LEN_W < 7 || MIN_LEN >= (64'd1 << LEN_W)) begin : g_bad_len
      $error("rxerr_stat_bank: MIN_LEN must fit in LEN_W bits");
   end

   logic [NUM_CTR-1:0] inc;
   logic [NUM_CTR-1:0] hit;
   logic [CNT_W-1:0]   cnt_arr [NUM_CTR];
   logic [CNT_W-1:0]   rd_sel;

   rxstat_qualify #(
      .LEN_W   (LEN_W),
      .MIN_LEN (MIN_LEN)
   ) u_qual (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_valid   (ev_valid),
      .ev_len     (ev_len),
      .ev_crc_bad (ev_crc_bad),
      .ev_sym_bad (ev_sym_bad),
      .rx_en      (rx_en),
      .inc        (inc)
   );

   rxstat_rd_decode #(
      .ADDR_W  (ADDR_W),
      .CRC_OFS (CRC_OFS),
      .SYM_OFS (SYM_OFS)
   ) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .hit     (hit)
   );

   for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
      rxstat_sat_ctr #(
         .CNT_W (CNT_W)
      ) u_ctr (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (inc[i]),
         .clr   (hit[i]),
         .cnt   (cnt_arr[i])
      );
   end

   always_comb begin
      rd_sel = '0;
      for (int i = 0; i < NUM_CTR; i++) begin
         if (hit[i]) rd_sel = rd_sel | cnt_arr[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_sel;
   end

   // R10: unmapped reads return zero
   assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && hit == '0) |=> (rd_data == '0));

   // R5: with reception off and no read, both counters hold
   assert_rxen_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en && !rd_en) |=> ($stable(cnt_arr[CTR_CRC]) && $stable(cnt_arr[CTR_SYM])));

   // R2: rd_data changes only after a read
   assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

endmodule

// File: tb/sim_rxerr_stat_bank.sv
`timescale 1ns/1ps
module sim_rxerr_stat_bank;

   localparam int CW  = 8;
   localparam int MAX = 255;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           ev_valid = 1'b0;
   logic [15:0]    ev_len = '0;
   logic           ev_crc_bad = 1'b0;
   logic           ev_sym_bad = 1'b0;
   logic           rx_en = 1'b0;
   logic           rd_en = 1'b0;
   logic [11:0]    rd_addr = '0;
   logic [CW-1:0]  rd_data;

   int n_chk  = 0;
   int n_fail = 0;
   int ec     = 0;
   int es     = 0;

   always #2.5 clk = ~clk;

   rxerr_stat_bank #(.CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_len(ev_len),
      .ev_crc_bad(ev_crc_bad), .ev_sym_bad(ev_sym_bad), .rx_en(rx_en),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic check(input int act, input int exp, input string req);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // One cycle: optional event plus optional read; entered and left at negedge
   task automatic step(input logic v, input int len, input logic c, input logic s,
                       input logic e, input logic rd, input int addr, input string req);
      int  ret;
      bit  ic, is;
      ev_valid = v; ev_len = len[15:0]; ev_crc_bad = c; ev_sym_bad = s;
      rx_en = e; rd_en = rd; rd_addr = addr[11:0];
      ret = 0;
      if (rd) ret = (addr == 0) ? ec : ((addr == 4) ? es : 0);
      ic = v && e && c && (len >= 64);
      is = v && e && s;
      if (rd && addr == 0) ec = ic ? 1 : 0;
      else if (ic && ec < MAX) ec++;
      if (rd && addr == 4) es = is ? 1 : 0;
      else if (is && es < MAX) es++;
      @(posedge clk);
      @(negedge clk);
      ev_valid = 0; rd_en = 0;
      if (rd) check(int'(rd_data), ret, req);
   endtask

   task automatic frame(input int len, input logic c, input logic s, input logic e);
      step(1, len, c, s, e, 0, 0, "");
   endtask

   task automatic rd(input int addr, input string req);
      step(0, 0, 0, 0, 1, 1, addr, req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      int lens [8] = '{0, 1, 63, 64, 65, 100, 1518, 65535};
      repeat (3) @(negedge clk);
      rst_n = 1;
      check(int'(rd_data), 0, "R1 rd_data after reset");
      rd(0, "R1 crc counter after reset");
      rd(4, "R1 sym counter after reset");

      // Sweep: length x flags x enable, reading both counters after each frame (R4 R5 R6 R7 R8)
      foreach (lens[i]) begin
         for (int f = 0; f < 8; f++) begin
            frame(lens[i], f[0], f[1], f[2]);
            rd(0, "R4 R5 R7 R8 crc after frame");
            rd(4, "R5 R6 R7 R8 sym after frame");
         end
      end

      // Accumulate, then read once (R2 R7)
      for (int k = 0; k < 10; k++) frame(64 + k, 1, 1, 1);
      frame(63, 1, 1, 1);
      rd(0, "R2 R4 accumulated crc");
      rd(0, "R2 crc cleared by read");
      rd(4, "R2 R6 accumulated sym");
      rd(4, "R2 sym cleared by read");

      // R11: event then immediate read
      frame(200, 1, 0, 1);
      rd(0, "R11 event visible next cycle");

      // R9: collisions of read and event
      for (int k = 0; k < 5; k++) frame(64, 0, 1, 1);
      step(1, 64, 0, 1, 1, 1, 4, "R9 collide returns old sym");
      rd(4, "R9 sym left at one");
      for (int k = 0; k < 3; k++) frame(80, 1, 0, 1);
      step(1, 80, 1, 1, 1, 1, 0, "R9 collide returns old crc");
      rd(0, "R9 crc left at one");
      rd(4, "R7 sym counted during crc read");
      step(1, 80, 1, 0, 0, 1, 0, "R5 R9 disabled event with read");
      rd(0, "R5 crc zero after disabled collide");

      // R10: unmapped reads, with and without events, no side effects
      for (int k = 0; k < 4; k++) frame(90, 1, 1, 1);
      rd(8, "R10 unmapped 0x008");
      rd(2, "R10 misaligned 0x002");
      rd('h100, "R10 unmapped 0x100");
      step(1, 90, 1, 1, 1, 1, 'hffc, "R10 unmapped with event");
      rd(0, "R10 crc kept after unmapped reads");
      rd(4, "R10 sym kept after unmapped reads");

      // R3: saturation and collision at saturation
      for (int k = 0; k < 300; k++) frame(64, 1, 1, 1);
      rd(0, "R3 crc saturated");
      rd(0, "R2 R3 crc cleared from max");
      for (int k = 0; k < 10; k++) frame(70, 0, 1, 0);
      step(1, 70, 0, 1, 1, 1, 4, "R3 R9 saturated sym with collide");
      rd(4, "R9 sym one after saturated read");
      for (int k = 0; k < 255; k++) frame(64, 0, 1, 1);
      rd(4, "R3 sym exactly at max");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule